// File: doc/BRIEF.md
# Linked-List DMA Channel

This block is one DMA channel that copies data between a host address space and a local address space through a single memory master port. Software programs it through a small register port. In direct mode it takes the transfer parameters from its own registers: host address, local address, byte count, and a direction bit in the pointer register. In list mode it walks a chain of 16-byte descriptors held in either space. For each descriptor it loads the parameters, moves the data, may zero the descriptor's count word, and then follows the next pointer until it reaches an element marked as the last one.

Every beat is a read from the source space followed by a write to the destination space. The beat size comes from the configured local bus width, and it shrinks for the final partial beat. An optional number of idle cycles follows every beat. A command/status byte controls the channel: it can enable, pause, start, abort, and clear the interrupt. A single level interrupt output reports channel completion and per-element completion.

Top module: `dma_chain_chan`

## Requirements
- R1: After reset the status byte reads 0, `irq_o` is 0 and no memory request is issued. While the channel is not busy, `mem_req_o` stays low.
- R2: A command write with both bit 1 (start) and bit 0 (enable) set starts an idle channel and clears the done and aborted status. A start written with enable 0 has no effect: busy and done stay 0, no memory access occurs and the count is unchanged.
- R3: Direct mode (mode bit 9 = 0) uses the direction in pointer register bit 3 (1 = local to host). Each beat reduces the count by the beat size and advances the host address by the same amount. On reaching a count of zero the channel sets done (status bit 4) and clears busy (status bit 6). The data written equals the data read from the source.
- R4: When mode bit 11 is 0, the local address advances with every beat. When mode bit 11 is 1, the local address stays constant.
- R5: Mode bits [1:0] set the beat size: 0 gives 1 byte, 1 gives 2 bytes, 2 or 3 give 4 bytes. The last beat is the smaller of the beat size and the remaining count, so an N-byte move takes ceil(N/size) writes.
- R6: Mode bits [5:2] give a number W of idle cycles with no request after each write beat. This lengthens a transfer by exactly W cycles per beat.
- R7: List mode (mode bit 9 = 1) reads the element at pointer bits [31:4]×16. It reads offset +0 (host address), +4 (local address), +8 (count) and +C (next pointer), from host space when pointer bit 0 is 1 and from local space otherwise. In the next-pointer word, bit 1 marks the last element and bit 3 sets that element's direction.
- R8: An element whose count is zero moves no data, and the walk continues to the next element.
- R9: With mode bit 16 set in list mode, after each element the channel writes 0 to that element's +8 word in the list's space.
- R10: `irq_o` is set on completion when mode bit 10 is 1. It is also set at the end of any list element whose next-pointer bit 2 is 1. A command write with bit 3 set clears it.
- R11: A command write with bit 2 set while busy stops the channel at the next beat boundary, with no further descriptor fetch. The channel then sets done and aborted (status bit 5), and the enable bit is left unchanged.
- R12: Clearing enable while busy pauses the channel: once any access in flight has finished, no new request is issued. Setting enable again resumes the transfer where it stopped.
- R13: The count register and the descriptor count field keep only their low 23 bits. Writing all ones to the count register reads back 0x7FFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register select: 0 mode, 1 host address, 2 local address, 3 count, 4 pointer, 5 command/status |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the selected register (combinational) |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_space_o | output | 1 | 1 = host space, 0 = local space |
| mem_addr_o | output | 32 | Byte address |
| mem_bytes_o | output | 3 | Bytes in this access (1, 2, 3 or 4) |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Acknowledge; read data is valid with it |
| mem_rdata_i | input | 32 | Read data |
| irq_o | output | 1 | Interrupt flag |

## Verification
Several rules are checked on every cycle by the assertions:
- the memory request is held steady until it is acknowledged;
- an idle channel is silent;
- a paused channel issues no new request;
- the count falls at every write beat;
- the local address holds when hold mode is on;
- the wait gap follows a beat;
- an abort leaves enable alone and always ends with done.

Other behaviours depend on memory contents and on sequences across elements, so only the bench scenarios can show them. These are the data actually copied, the beat counts for each width and length, the exact cycle cost of the wait states, the descriptor walk with a zero-length element and count write-back, and the interrupt sources.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CHECK, S_RD, S_WR, S_WAIT, S_WB, S_NEXT
  } dma_state_e;

  localparam logic [2:0] RA_MODE  = 3'd0;
  localparam logic [2:0] RA_HADDR = 3'd1;
  localparam logic [2:0] RA_LADDR = 3'd2;
  localparam logic [2:0] RA_COUNT = 3'd3;
  localparam logic [2:0] RA_PTR   = 3'd4;
  localparam logic [2:0] RA_CMD   = 3'd5;

  localparam int MB_CHAIN    = 9;
  localparam int MB_DONE_IRQ = 10;
  localparam int MB_HOLD     = 11;
  localparam int MB_CLRCNT   = 16;

  localparam int PB_HOST = 0;
  localparam int PB_END  = 1;
  localparam int PB_LINK = 2;
  localparam int PB_DIR  = 3;

  localparam int CB_EN     = 0;
  localparam int CB_START  = 1;
  localparam int CB_ABORT  = 2;
  localparam int CB_CLRIRQ = 3;
endpackage

// File: rtl/dma_beat_size.sv
module dma_beat_size #(
  parameter int CNT_W = 23
) (
  input  logic [1:0]       width_i,
  input  logic [CNT_W-1:0] remain_i,
  output logic [2:0]       step_o
);
  logic [2:0] full;
  always_comb begin
    case (width_i)
      2'd0:    full = 3'd1;
      2'd1:    full = 3'd2;
      default: full = 3'd4;
    endcase
    step_o = (remain_i < CNT_W'(full)) ? remain_i[2:0] : full;
  end
endmodule

// File: rtl/dma_wait_timer.sv
module dma_wait_timer #(
  parameter int WS_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [WS_W-1:0] val_i,
  input  logic            run_i,
  output logic            expired_o
);
  logic [WS_W-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= val_i - WS_W'(1);
    else if (run_i && cnt_q != '0) cnt_q <= cnt_q - WS_W'(1);
  end
  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/dma_chain_chan.sv
module dma_chain_chan
  import dma_chain_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 23,
  parameter int WS_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic              mem_space_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [2:0]        mem_bytes_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              irq_o
);
  localparam int WS_LO = 2;

  dma_state_e        st_q;
  logic [31:0]       mode_q, nxt_q, buf_q;
  logic [ADDR_W-1:0] haddr_q, laddr_q, dptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [1:0]        idx_q;
  logic en_q, busy_q, done_q, abrt_q, irq_q, abort_pend_q;
  logic dir_q, last_q, link_q;

  logic [2:0]        step;
  logic [WS_W-1:0]   ws;
  logic              wait_exp, wait_load;
  logic [ADDR_W-1:0] desc_base;
  logic              cmd_wr;

  assign ws        = mode_q[WS_LO+WS_W-1:WS_LO];
  assign desc_base = {dptr_q[ADDR_W-1:4], 4'h0};
  assign wait_load = (st_q == S_WR) && mem_ack_i && (ws != '0);
  assign cmd_wr    = reg_we_i && (reg_addr_i == RA_CMD);

  dma_beat_size #(.CNT_W(CNT_W)) u_beat (
    .width_i (mode_q[1:0]),
    .remain_i(cnt_q),
    .step_o  (step)
  );

  dma_wait_timer #(.WS_W(WS_W)) u_wait (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (wait_load),
    .val_i    (ws),
    .run_i    (st_q == S_WAIT),
    .expired_o(wait_exp)
  );

  // memory master outputs
  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_space_o = 1'b0;
    mem_addr_o  = '0;
    mem_bytes_o = 3'd4;
    mem_wdata_o = '0;
    case (st_q)
      S_FETCH: begin
        mem_req_o   = 1'b1;
        mem_space_o = dptr_q[PB_HOST];
        mem_addr_o  = desc_base + ADDR_W'({idx_q, 2'b00});
      end
      S_RD: begin
        mem_req_o   = 1'b1;
        mem_space_o = ~dir_q;
        mem_addr_o  = dir_q ? laddr_q : haddr_q;
        mem_bytes_o = step;
      end
      S_WR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_space_o = dir_q;
        mem_addr_o  = dir_q ? haddr_q : laddr_q;
        mem_bytes_o = step;
        mem_wdata_o = buf_q;
      end
      S_WB: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_space_o = dptr_q[PB_HOST];
        mem_addr_o  = desc_base + ADDR_W'(8);
      end
      default: ;
    endcase
  end

  always_comb begin
    case (reg_addr_i)
      RA_MODE:  reg_rdata_o = mode_q;
      RA_HADDR: reg_rdata_o = 32'(haddr_q);
      RA_LADDR: reg_rdata_o = 32'(laddr_q);
      RA_COUNT: reg_rdata_o = 32'(cnt_q);
      RA_PTR:   reg_rdata_o = 32'(dptr_q);
      RA_CMD:   reg_rdata_o = {25'd0, busy_q, abrt_q, done_q, 3'd0, en_q};
      default:  reg_rdata_o = '0;
    endcase
  end

  assign irq_o = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE;
      mode_q <= '0; nxt_q <= '0; buf_q <= '0;
      haddr_q <= '0; laddr_q <= '0; dptr_q <= '0; cnt_q <= '0; idx_q <= '0;
      en_q <= 1'b0; busy_q <= 1'b0; done_q <= 1'b0; abrt_q <= 1'b0;
      irq_q <= 1'b0; abort_pend_q <= 1'b0;
      dir_q <= 1'b0; last_q <= 1'b0; link_q <= 1'b0;
    end else begin
      if (reg_we_i) begin
        case (reg_addr_i)
          RA_MODE:  mode_q  <= reg_wdata_i;
          RA_HADDR: haddr_q <= ADDR_W'(reg_wdata_i);
          RA_LADDR: laddr_q <= ADDR_W'(reg_wdata_i);
          RA_COUNT: cnt_q   <= reg_wdata_i[CNT_W-1:0];
          RA_PTR:   dptr_q  <= ADDR_W'(reg_wdata_i);
          default: ;
        endcase
      end
      if (cmd_wr) begin
        if (reg_wdata_i[CB_ABORT]) begin
          if (busy_q) abort_pend_q <= 1'b1;
        end else begin
          en_q <= reg_wdata_i[CB_EN];
        end
        if (reg_wdata_i[CB_CLRIRQ]) irq_q <= 1'b0;
        if (reg_wdata_i[CB_EN] && reg_wdata_i[CB_START] && !reg_wdata_i[CB_ABORT] && !busy_q) begin
          busy_q <= 1'b1;
          done_q <= 1'b0;
          abrt_q <= 1'b0;
          dir_q  <= dptr_q[PB_DIR];
          last_q <= 1'b1;
          link_q <= 1'b0;
          idx_q  <= '0;
          st_q   <= mode_q[MB_CHAIN] ? S_FETCH : S_CHECK;
        end
      end

      case (st_q)
        S_FETCH: if (mem_ack_i) begin
          idx_q <= idx_q + 2'd1;
          case (idx_q)
            2'd0: haddr_q <= ADDR_W'(mem_rdata_i);
            2'd1: laddr_q <= ADDR_W'(mem_rdata_i);
            2'd2: cnt_q   <= mem_rdata_i[CNT_W-1:0];
            default: begin
              nxt_q  <= mem_rdata_i;
              dir_q  <= mem_rdata_i[PB_DIR];
              last_q <= mem_rdata_i[PB_END];
              link_q <= mem_rdata_i[PB_LINK];
              st_q   <= S_CHECK;
            end
          endcase
        end
        S_CHECK: begin
          if (abort_pend_q) begin
            st_q <= S_IDLE; busy_q <= 1'b0; done_q <= 1'b1; abrt_q <= 1'b1;
            abort_pend_q <= 1'b0;
            if (mode_q[MB_DONE_IRQ]) irq_q <= 1'b1;
          end else if (en_q) begin
            if (cnt_q == '0) begin
              if (link_q && mode_q[MB_CHAIN]) irq_q <= 1'b1;
              st_q <= (mode_q[MB_CHAIN] && mode_q[MB_CLRCNT]) ? S_WB : S_NEXT;
            end else begin
              st_q <= S_RD;
            end
          end
        end
        S_RD: if (mem_ack_i) begin
          buf_q <= mem_rdata_i;
          st_q  <= S_WR;
        end
        S_WR: if (mem_ack_i) begin
          haddr_q <= haddr_q + ADDR_W'(step);
          if (!mode_q[MB_HOLD]) laddr_q <= laddr_q + ADDR_W'(step);
          cnt_q <= cnt_q - CNT_W'(step);
          st_q  <= (ws != '0) ? S_WAIT : S_CHECK;
        end
        S_WAIT: if (wait_exp) st_q <= S_CHECK;
        S_WB: if (mem_ack_i) st_q <= S_NEXT;
        S_NEXT: begin
          if (last_q || abort_pend_q) begin
            st_q <= S_IDLE; busy_q <= 1'b0; done_q <= 1'b1; abrt_q <= abort_pend_q;
            abort_pend_q <= 1'b0;
            if (mode_q[MB_DONE_IRQ]) irq_q <= 1'b1;
          end else if (en_q) begin
            dptr_q <= ADDR_W'(nxt_q);
            idx_q  <= '0;
            st_q   <= S_FETCH;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dma_chain_chan_sva.sv
module dma_chain_chan_sva
  import dma_chain_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 23,
  parameter int WS_W   = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input dma_state_e        st_i,
  input logic              mem_req_i,
  input logic              mem_ack_i,
  input logic [ADDR_W-1:0] mem_addr_i,
  input logic              busy_i,
  input logic              en_i,
  input logic              done_i,
  input logic              abrt_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [ADDR_W-1:0] laddr_i,
  input logic              hold_i,
  input logic [WS_W-1:0]   ws_i,
  input logic              reg_we_i,
  input logic [2:0]        reg_addr_i,
  input logic [31:0]       reg_wdata_i
);
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !mem_req_i);

  a_r7_req_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i && !mem_ack_i |=> mem_req_i && $stable(mem_addr_i));

  a_r3_count_falls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == S_WR) && mem_ack_i && !reg_we_i |=> cnt_i < $past(cnt_i));

  a_r4_local_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i && (st_i == S_WR) && mem_ack_i && !reg_we_i |=> $stable(laddr_i));

  a_r6_wait_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == S_WR) && mem_ack_i && (ws_i != '0) |=> !mem_req_i);

  a_r11_abort_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(abrt_i) |-> done_i && !busy_i);

  a_r11_enable_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && (reg_addr_i == RA_CMD) && reg_wdata_i[CB_ABORT] |=> $stable(en_i));

  a_r12_pause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !mem_req_i && !reg_we_i |=> !mem_req_i);
endmodule

bind dma_chain_chan dma_chain_chan_sva #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WS_W(WS_W)) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .st_i       (st_q),
  .mem_req_i  (mem_req_o),
  .mem_ack_i  (mem_ack_i),
  .mem_addr_i (mem_addr_o),
  .busy_i     (busy_q),
  .en_i       (en_q),
  .done_i     (done_q),
  .abrt_i     (abrt_q),
  .cnt_i      (cnt_q),
  .laddr_i    (laddr_q),
  .hold_i     (mode_q[11]),
  .ws_i       (ws),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i)
);

// File: tb/dma_chain_chan_test.sv
`timescale 1ns/1ps
module dma_chain_chan_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_space;
  logic [31:0] mem_addr, mem_wdata;
  logic [2:0]  mem_bytes;
  logic        mem_ack;
  logic [31:0] mem_rdata;
  logic        irq;

  dma_chain_chan uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_space_o(mem_space), .mem_addr_o(mem_addr),
    .mem_bytes_o(mem_bytes), .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .irq_o(irq)
  );

  // memory model: 256 words per space, ack every second cycle
  logic [31:0] hmem [256];
  logic [31:0] lmem [256];
  logic        init_mem = 1'b0, poke_en = 1'b0, poke_host = 1'b0;
  logic [7:0]  poke_idx = '0;
  logic [31:0] poke_val = '0;
  int          wr_count;
  logic [7:0]  midx;
  assign midx = mem_addr[9:2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      mem_rdata <= '0;
      wr_count <= 0;
    end else begin
      if (init_mem) begin
        for (int i = 0; i < 256; i++) begin
          hmem[i] <= 32'h4800_0000 | i;
          lmem[i] <= 32'h1C00_0000 | i;
        end
        wr_count <= 0;
      end else if (poke_en) begin
        if (poke_host) hmem[poke_idx] <= poke_val;
        else           lmem[poke_idx] <= poke_val;
      end
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) mem_rdata <= mem_space ? hmem[midx] : lmem[midx];
      if (mem_req && mem_ack && mem_we) begin
        if (mem_space) hmem[midx] <= mem_wdata;
        else           lmem[midx] <= mem_wdata;
        wr_count <= wr_count + 1;
      end
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic mem_init();
    @(negedge clk); init_mem = 1'b1;
    @(negedge clk); init_mem = 1'b0;
  endtask

  task automatic poke(input logic host, input logic [7:0] idx, input logic [31:0] v);
    @(negedge clk);
    poke_en = 1'b1; poke_host = host; poke_idx = idx; poke_val = v;
    @(negedge clk); poke_en = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    logic [31:0] s;
    cyc = 0;
    s = '0;
    while (s[4] !== 1'b1 && cyc < 5000) begin
      rd_reg(3'd5, s);
      cyc++;
    end
    if (cyc >= 5000) check("R3 done timeout", 32'd0, 32'd1);
  endtask

  task automatic run_plain(input int w, input int n, input int h, input int dir);
    int step, beats, cyc;
    logic [31:0] v;
    step  = (w == 0) ? 1 : (w == 1) ? 2 : 4;
    beats = (n + step - 1) / step;
    mem_init();
    wr_reg(3'd0, (h << 11) | w);
    wr_reg(3'd1, 32'h100);
    wr_reg(3'd2, 32'h200);
    wr_reg(3'd3, n);
    wr_reg(3'd4, dir << 3);
    wr_reg(3'd5, 32'h3);
    wait_done(cyc);
    check("R5 beat count", wr_count, beats);
    rd_reg(3'd1, v); check("R3 host address end", v, 32'h100 + n);
    rd_reg(3'd2, v); check("R4 local address end", v, h ? 32'h200 : 32'h200 + n);
    rd_reg(3'd3, v); check("R3 count zero", v, 0);
    rd_reg(3'd5, v); check("R3 status done idle", v, 32'h11);
    if (w == 2 && h == 0) begin
      for (int k = 0; k < beats; k++) begin
        if (dir == 0) check("R3 data host to local", lmem[128 + k], 32'h4800_0000 | (64 + k));
        else          check("R3 data local to host", hmem[64 + k], 32'h1C00_0000 | (128 + k));
      end
    end
  endtask

  task automatic timed_run(input int ws, output int cyc);
    mem_init();
    wr_reg(3'd0, (ws << 2) | 2);
    wr_reg(3'd1, 32'h100);
    wr_reg(3'd2, 32'h200);
    wr_reg(3'd3, 12);
    wr_reg(3'd4, 0);
    wr_reg(3'd5, 32'h3);
    wait_done(cyc);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, c1, c2;
    int w1, w2, cyc0, cyc3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd_reg(3'd5, v); check("R1 reset status", v, 0);
    check("R1 reset irq", {31'd0, irq}, 0);
    check("R1 reset no request", {31'd0, mem_req}, 0);
    rd_reg(3'd0, v); check("R1 reset mode", v, 0);

    // R13 count width
    wr_reg(3'd3, 32'hFFFF_FFFF);
    rd_reg(3'd3, v); check("R13 count masked", v, 32'h7F_FFFF);

    // R2 start without enable
    mem_init();
    wr_reg(3'd3, 8);
    wr_reg(3'd5, 32'h2);
    repeat (10) @(negedge clk);
    rd_reg(3'd5, v); check("R2 start without enable ignored", v, 0);
    rd_reg(3'd3, v); check("R2 count untouched", v, 8);
    check("R2 no memory writes", wr_count, 0);

    // R3 R4 R5 sweep
    for (int w = 0; w < 3; w++)
      for (int n = 0; n < 10; n++)
        for (int h = 0; h < 2; h++)
          run_plain(w, n, h, n & 1);
    check("R10 no irq without sources", {31'd0, irq}, 0);

    // R6 wait states
    timed_run(0, cyc0);
    timed_run(3, cyc3);
    check("R6 wait cycles per beat", cyc3 - cyc0, 9);

    // R7 R8 R9 R10 chained walk, list in local space
    mem_init();
    poke(0, 8'd192, 32'h100); poke(0, 8'd193, 32'h200); poke(0, 8'd194, 8);
    poke(0, 8'd195, 32'h314);
    poke(0, 8'd196, 32'h0);   poke(0, 8'd197, 32'h0);   poke(0, 8'd198, 32'h0080_0000);
    poke(0, 8'd199, 32'h320);
    poke(0, 8'd200, 32'h140); poke(0, 8'd201, 32'h240); poke(0, 8'd202, 4);
    poke(0, 8'd203, 32'h00A);
    wr_reg(3'd0, 32'h0001_0202);
    wr_reg(3'd4, 32'h300);
    wr_reg(3'd5, 32'h3);
    wait_done(w1);
    check("R7 element 0 word 0", lmem[128], 32'h4800_0040);
    check("R7 element 0 word 1", lmem[129], 32'h4800_0041);
    check("R8 element after empty one, reversed", hmem[80], 32'h1C00_0090);
    check("R9 count cleared 0", lmem[194], 0);
    check("R9 count cleared 1", lmem[198], 0);
    check("R9 count cleared 2", lmem[202], 0);
    check("R9 total writes", wr_count, 6);
    check("R10 link irq", {31'd0, irq}, 1);
    wr_reg(3'd5, 32'h9);
    @(negedge clk);
    check("R10 irq cleared", {31'd0, irq}, 0);

    // R7 R10 list in host space, done interrupt
    mem_init();
    poke(1, 8'd240, 32'h180); poke(1, 8'd241, 32'h280); poke(1, 8'd242, 4);
    poke(1, 8'd243, 32'h2);
    wr_reg(3'd0, 32'h0000_0602);
    wr_reg(3'd4, 32'h3C1);
    wr_reg(3'd5, 32'h3);
    wait_done(w1);
    check("R7 host-resident list data", lmem[160], 32'h4800_0060);
    check("R9 no clear when mode off", hmem[242], 4);
    check("R10 done irq", {31'd0, irq}, 1);
    wr_reg(3'd5, 32'h9);

    // R11 abort
    mem_init();
    wr_reg(3'd0, 0);
    wr_reg(3'd1, 32'h100); wr_reg(3'd2, 32'h200);
    wr_reg(3'd3, 200); wr_reg(3'd4, 0);
    wr_reg(3'd5, 32'h3);
    repeat (30) @(negedge clk);
    wr_reg(3'd5, 32'h4);
    wait_done(w1);
    rd_reg(3'd5, v); check("R11 status abort done enable", v, 32'h31);
    rd_reg(3'd3, c1);
    check("R11 stopped early", {31'd0, (c1 != 0 && c1 < 200)}, 1);
    check("R11 beats match count", wr_count, 200 - c1);

    // R12 pause and resume
    mem_init();
    wr_reg(3'd3, 40);
    wr_reg(3'd5, 32'h3);
    repeat (10) @(negedge clk);
    wr_reg(3'd5, 32'h0);
    repeat (6) @(negedge clk);
    rd_reg(3'd3, c1); w1 = wr_count;
    repeat (20) @(negedge clk);
    rd_reg(3'd3, c2); w2 = wr_count;
    check("R12 count frozen", c2, c1);
    check("R12 no writes while paused", w2, w1);
    wr_reg(3'd5, 32'h1);
    wait_done(w1);
    rd_reg(3'd3, v); check("R12 resumed to zero", v, 0);
    check("R12 all bytes moved", wr_count, 40);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule